// File: doc/BRIEF.md
# Three-Dimensional Transfer Address Generator

This block turns one loaded transfer description into a stream of array commands. Each command carries a source address, a destination address and a byte count. The transfer is seen as a block of frames, each frame as a run of arrays and each array as a run of bytes. The generator walks the frame and array dimensions. It steps each side by its own signed array stride and frame stride. It keeps the remaining array and frame counts, and it raises a one-cycle done pulse once the final command has been taken.

Work is paced by sync events. In array-sync mode each event releases a single array command. In frame-sync mode each event releases every array of the next frame, one after another. A side can be held at a fixed address, as needed when a FIFO register is the target. The 3-bit FIFO width code is then carried beside every command.

Top module: `tri_dim_agen`

## Requirements
- R1: After reset `cmdValid` and `done` are both low.
- R2: `cmdBytes` equals bits 15:0 of `cfgCounts` (bytes per array). Bits 31:16 of `cfgCounts` give the arrays per frame and `cfgCcnt` gives the frames per block. In `cfgBIdx` and `cfgCIdx`, bits 15:0 are the source stride and bits 31:16 are the destination stride. Each stride is a signed byte offset.
- R3: In array-sync mode (`cfgOpt[2]`=0) each sync event yields exactly one command, and `cmdValid` falls after it is accepted. Within a frame, each address moves by its array stride.
- R4: In array-sync mode the first array of a new frame sits at the last array's address plus the frame stride. Every frame after the first holds `cfgReload` arrays.
- R5: In frame-sync mode (`cfgOpt[2]`=1) one sync event yields all arrays of a frame, with no idle cycle between accepted commands. Array b of frame f sits at start + f*frameStride + b*arrayStride.
- R6: `cfgOpt[0]` holds the source address fixed and `cfgOpt[1]` holds the destination address fixed, with both strides ignored on that side. `cmdFifoW` reports `cfgOpt[5:3]`.
- R7: While `cmdValid` is high and `cmdReady` is low, the command outputs keep their values.
- R8: `done` is high for exactly the one cycle after the last array of the last frame is accepted, and it is low at every other time.
- R9: A sync event is ignored when no transfer description is loaded, both after reset and after a block has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | Captures the cfg* inputs as a new transfer description |
| cfgSrc | input | ADDR_W | Source start address |
| cfgDst | input | ADDR_W | Destination start address |
| cfgCounts | input | 2*CNT_W | Bytes per array (low half), arrays per frame (high half) |
| cfgCcnt | input | CNT_W | Frames per block |
| cfgReload | input | CNT_W | Arrays per frame after the first frame in array-sync mode |
| cfgBIdx | input | 2*CNT_W | Array strides: source low half, destination high half |
| cfgCIdx | input | 2*CNT_W | Frame strides: source low half, destination high half |
| cfgOpt | input | 6 | bit0 source hold, bit1 destination hold, bit2 frame-sync, bits5:3 FIFO width |
| syncEv | input | 1 | Sync event |
| cmdValid | output | 1 | Command available |
| cmdReady | input | 1 | Downstream accepts the command |
| cmdSrc | output | ADDR_W | Command source address |
| cmdDst | output | ADDR_W | Command destination address |
| cmdBytes | output | CNT_W | Command byte count |
| cmdFifoW | output | 3 | FIFO width code |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take several things for granted about the inputs. Every count loaded is at least one. A new description is loaded only when no command is waiting. The address width is larger than the count width. The stimulus keeps to these rules: it loads only between blocks, and its count sweeps start at one. It also steps through array and frame counts of one to three in both sync modes, with strides of both signs, and inserts downstream stalls on alternate arrays.

// File: rtl/agen_pkg.sv
package agen_pkg;
  // option word bit positions
  localparam int OPT_W        = 6;
  localparam int OPT_SRC_HOLD = 0;
  localparam int OPT_DST_HOLD = 1;
  localparam int OPT_FRAME    = 2;
  localparam int OPT_FW_LSB   = 3;
  localparam int FIFO_W       = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic init;        // capture start addresses and strides
    logic stepB;       // advance by array stride
    logic stepCLast;   // advance by frame stride from last array
    logic stepCFrame;  // advance by frame stride from frame start
  } agenStep_t;
endpackage

// File: rtl/agen_side.sv
module agen_side #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  agen_pkg::agenStep_t   step,
  input  logic [ADDR_W-1:0]     ldBase,
  input  logic [CNT_W-1:0]      ldBIdx,
  input  logic [CNT_W-1:0]      ldCIdx,
  input  logic                  ldHold,
  output logic [ADDR_W-1:0]     addr
);
  localparam int EXT_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] cur, frm, bStep, cStep;
  logic holdR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cur   <= '0;
      frm   <= '0;
      bStep <= '0;
      cStep <= '0;
      holdR <= 1'b0;
    end else if (step.init) begin
      cur   <= ldBase;
      frm   <= ldBase;
      bStep <= ldHold ? '0 : {{EXT_W{ldBIdx[CNT_W-1]}}, ldBIdx};
      cStep <= ldHold ? '0 : {{EXT_W{ldCIdx[CNT_W-1]}}, ldCIdx};
      holdR <= ldHold;
    end else if (step.stepB) begin
      cur <= cur + bStep;
    end else if (step.stepCLast) begin
      cur <= cur + cStep;
      frm <= cur + cStep;
    end else if (step.stepCFrame) begin
      cur <= frm + cStep;
      frm <= frm + cStep;
    end
  end

  assign addr = cur;

  // R6
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdR && !step.init) |=> $stable(cur));
endmodule

// File: rtl/agen_dp.sv
module agen_dp #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  agen_pkg::agenStep_t          step,
  input  logic [ADDR_W-1:0]            cfgSrc,
  input  logic [ADDR_W-1:0]            cfgDst,
  input  logic [CNT_W-1:0]             cfgAcnt,
  input  logic [2*CNT_W-1:0]           cfgBIdx,
  input  logic [2*CNT_W-1:0]           cfgCIdx,
  input  logic [1:0]                   cfgHold,
  input  logic [agen_pkg::FIFO_W-1:0]  cfgFifoW,
  output logic [ADDR_W-1:0]            cmdSrc,
  output logic [ADDR_W-1:0]            cmdDst,
  output logic [CNT_W-1:0]             cmdBytes,
  output logic [agen_pkg::FIFO_W-1:0]  cmdFifoW
);
  localparam int SIDES = 2;

  logic [ADDR_W-1:0] sideBase [SIDES];
  logic [ADDR_W-1:0] sideAddr [SIDES];
  logic [CNT_W-1:0]  acntR;
  logic [agen_pkg::FIFO_W-1:0] fifoWR;

  assign sideBase[0] = cfgSrc;
  assign sideBase[1] = cfgDst;

  // side 0 = source (low halves), side 1 = destination (high halves)
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    agen_side #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_side (
      .clk    (clk),
      .rstN   (rstN),
      .step   (step),
      .ldBase (sideBase[s]),
      .ldBIdx (cfgBIdx[s*CNT_W +: CNT_W]),
      .ldCIdx (cfgCIdx[s*CNT_W +: CNT_W]),
      .ldHold (cfgHold[s]),
      .addr   (sideAddr[s])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acntR  <= '0;
      fifoWR <= '0;
    end else if (step.init) begin
      acntR  <= cfgAcnt;
      fifoWR <= cfgFifoW;
    end
  end

  assign cmdSrc   = sideAddr[0];
  assign cmdDst   = sideAddr[1];
  assign cmdBytes = acntR;
  assign cmdFifoW = fifoWR;
endmodule

// File: rtl/agen_ctrl.sv
module agen_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgLoad,
  input  logic [CNT_W-1:0]    cfgBcnt,
  input  logic [CNT_W-1:0]    cfgCcnt,
  input  logic [CNT_W-1:0]    cfgReload,
  input  logic                cfgFrameSync,
  input  logic                syncEv,
  input  logic                cmdReady,
  output logic                cmdValid,
  output logic                done,
  output agen_pkg::agenStep_t step
);
  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_ISSUE} ctrlState_t;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  ctrlState_t state;
  logic [CNT_W-1:0] bLeft, cLeft, bFull, bRld;
  logic frameMode;
  logic accept, lastArr, lastFrame;

  assign accept    = (state == S_ISSUE) && cmdReady && !cfgLoad;
  assign lastArr   = (bLeft == ONE);
  assign lastFrame = (cLeft == ONE);
  assign cmdValid  = (state == S_ISSUE);

  always_comb begin
    step            = '0;
    step.init       = cfgLoad;
    step.stepB      = accept && !lastArr;
    step.stepCLast  = accept && lastArr && !lastFrame && !frameMode;
    step.stepCFrame = accept && lastArr && !lastFrame && frameMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bLeft     <= '0;
      cLeft     <= '0;
      bFull     <= '0;
      bRld      <= '0;
      frameMode <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= accept && lastArr && lastFrame;
      if (cfgLoad) begin
        state     <= S_ARMED;
        bLeft     <= cfgBcnt;
        cLeft     <= cfgCcnt;
        bFull     <= cfgBcnt;
        bRld      <= cfgReload;
        frameMode <= cfgFrameSync;
      end else begin
        case (state)
          S_ARMED: if (syncEv) state <= S_ISSUE;
          S_ISSUE: if (cmdReady) begin
            if (!lastArr) begin
              bLeft <= bLeft - ONE;
              state <= frameMode ? S_ISSUE : S_ARMED;
            end else if (!lastFrame) begin
              cLeft <= cLeft - ONE;
              bLeft <= frameMode ? bFull : bRld;
              state <= S_ARMED;
            end else begin
              cLeft <= '0;
              state <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  counts_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> (bLeft != '0 && cLeft != '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(cmdValid && cmdReady));

  // R9
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !cfgLoad) |=> !cmdValid);

  // R3
  one_per_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && !frameMode && !cfgLoad) |=> !cmdValid);
endmodule

// File: rtl/tri_dim_agen.sv
module tri_dim_agen #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgLoad,
  input  logic [ADDR_W-1:0]      cfgSrc,
  input  logic [ADDR_W-1:0]      cfgDst,
  input  logic [2*CNT_W-1:0]     cfgCounts,
  input  logic [CNT_W-1:0]       cfgCcnt,
  input  logic [CNT_W-1:0]       cfgReload,
  input  logic [2*CNT_W-1:0]     cfgBIdx,
  input  logic [2*CNT_W-1:0]     cfgCIdx,
  input  logic [5:0]             cfgOpt,
  input  logic                   syncEv,
  output logic                   cmdValid,
  input  logic                   cmdReady,
  output logic [ADDR_W-1:0]      cmdSrc,
  output logic [ADDR_W-1:0]      cmdDst,
  output logic [CNT_W-1:0]       cmdBytes,
  output logic [2:0]             cmdFifoW,
  output logic                   done
);
  import agen_pkg::*;

  agenStep_t step;

  agen_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgLoad      (cfgLoad),
    .cfgBcnt      (cfgCounts[2*CNT_W-1:CNT_W]),
    .cfgCcnt      (cfgCcnt),
    .cfgReload    (cfgReload),
    .cfgFrameSync (cfgOpt[OPT_FRAME]),
    .syncEv       (syncEv),
    .cmdReady     (cmdReady),
    .cmdValid     (cmdValid),
    .done         (done),
    .step         (step)
  );

  agen_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .step     (step),
    .cfgSrc   (cfgSrc),
    .cfgDst   (cfgDst),
    .cfgAcnt  (cfgCounts[CNT_W-1:0]),
    .cfgBIdx  (cfgBIdx),
    .cfgCIdx  (cfgCIdx),
    .cfgHold  ({cfgOpt[OPT_DST_HOLD], cfgOpt[OPT_SRC_HOLD]}),
    .cfgFifoW (cfgOpt[OPT_FW_LSB +: FIFO_W]),
    .cmdSrc   (cmdSrc),
    .cmdDst   (cmdDst),
    .cmdBytes (cmdBytes),
    .cmdFifoW (cmdFifoW)
  );

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady && !cfgLoad) |=>
      (cmdValid && $stable(cmdSrc) && $stable(cmdDst) && $stable(cmdBytes)));
endmodule

// File: tb/test_tri_dim_agen.sv
module test_tri_dim_agen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic [31:0] cfgSrc = '0, cfgDst = '0, cfgCounts = '0, cfgBIdx = '0, cfgCIdx = '0;
  logic [15:0] cfgCcnt = '0, cfgReload = '0;
  logic [5:0]  cfgOpt = '0;
  logic syncEv = 1'b0, cmdReady = 1'b0;
  logic cmdValid, done;
  logic [31:0] cmdSrc, cmdDst;
  logic [15:0] cmdBytes;
  logic [2:0]  cmdFifoW;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  tri_dim_agen i_tri_dim_agen (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgSrc(cfgSrc), .cfgDst(cfgDst),
    .cfgCounts(cfgCounts), .cfgCcnt(cfgCcnt), .cfgReload(cfgReload),
    .cfgBIdx(cfgBIdx), .cfgCIdx(cfgCIdx), .cfgOpt(cfgOpt), .syncEv(syncEv),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdSrc(cmdSrc), .cmdDst(cmdDst),
    .cmdBytes(cmdBytes), .cmdFifoW(cmdFifoW), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic runSet(input bit fs, input bit hs, input bit hd, input logic [2:0] fw,
                        input int A, input int B, input int C, input int R,
                        input logic [15:0] bS, input logic [15:0] bD,
                        input logic [15:0] cS, input logic [15:0] cD,
                        input logic [31:0] baseS, input logic [31:0] baseD);
    logic [31:0] stBS, stBD, stCS, stCD, eS, eD;
    stBS = hs ? 32'd0 : sx(bS);
    stCS = hs ? 32'd0 : sx(cS);
    stBD = hd ? 32'd0 : sx(bD);
    stCD = hd ? 32'd0 : sx(cD);
    // load
    cfgSrc = baseS; cfgDst = baseD;
    cfgCounts = {16'(B), 16'(A)}; cfgCcnt = 16'(C); cfgReload = 16'(R);
    cfgBIdx = {bD, bS}; cfgCIdx = {cD, cS};
    cfgOpt = {fw, fs, hd, hs};
    cfgLoad = 1'b1;
    tick();
    cfgLoad = 1'b0;
    chk(cmdValid == 1'b0, "R3 no command before event", 64'(cmdValid), 64'd0);
    eS = baseS; eD = baseD;
    for (int f = 0; f < C; f++) begin
      int nb;
      nb = (f == 0 || fs) ? B : R;
      for (int b = 0; b < nb; b++) begin
        bit lastAll;
        if (fs) begin
          // R5 closed-form frame-sync address
          eS = baseS + 32'(f) * stCS + 32'(b) * stBS;
          eD = baseD + 32'(f) * stCD + 32'(b) * stBD;
        end
        if (!fs || b == 0) begin
          syncEv = 1'b1;
          tick();
          syncEv = 1'b0;
        end
        if (((f + b) % 2) == 1) begin
          cmdReady = 1'b0;
          tick();
          chk(cmdValid == 1'b1, "R7 valid held in stall", 64'(cmdValid), 64'd1);
        end
        chk(cmdValid == 1'b1, fs ? "R5 valid" : "R3 valid", 64'(cmdValid), 64'd1);
        chk(cmdSrc == eS, fs ? "R5 src" : (b == 0 && f > 0 ? "R4 src" : "R3 src"), 64'(cmdSrc), 64'(eS));
        chk(cmdDst == eD, fs ? "R5 dst" : (b == 0 && f > 0 ? "R4 dst" : "R3 dst"), 64'(cmdDst), 64'(eD));
        chk(cmdBytes == 16'(A), "R2 byte count", 64'(cmdBytes), 64'(A));
        chk(cmdFifoW == fw, "R6 fifo width", 64'(cmdFifoW), 64'(fw));
        cmdReady = 1'b1;
        tick();
        cmdReady = 1'b0;
        lastAll = (f == C - 1) && (b == nb - 1);
        chk(done == lastAll, "R8 done timing", 64'(done), 64'(lastAll));
        if (!fs || b == nb - 1)
          chk(cmdValid == 1'b0, fs ? "R5 frame end" : "R3 one per event", 64'(cmdValid), 64'd0);
        else
          chk(cmdValid == 1'b1, "R5 back-to-back", 64'(cmdValid), 64'd1);
        if (!fs) begin
          // R4 step from last array's address
          if (b < nb - 1) begin eS = eS + stBS; eD = eD + stBD; end
          else begin eS = eS + stCS; eD = eD + stCD; end
        end
      end
    end
    tick();
    chk(done == 1'b0, "R8 done one cycle", 64'(done), 64'd0);
    chk(cmdValid == 1'b0, "R9 idle after block", 64'(cmdValid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmdValid == 1'b0, "R1 valid in reset", 64'(cmdValid), 64'd0);
    chk(done == 1'b0, "R1 done in reset", 64'(done), 64'd0);
    rstN = 1'b1;
    tick();
    chk(cmdValid == 1'b0, "R1 valid after reset", 64'(cmdValid), 64'd0);
    // R9 event with nothing loaded
    syncEv = 1'b1;
    tick();
    syncEv = 1'b0;
    chk(cmdValid == 1'b0, "R9 event before load", 64'(cmdValid), 64'd0);
    tick();
    chk(cmdValid == 1'b0, "R9 event before load later", 64'(cmdValid), 64'd0);

    // sweep both modes over small counts, signed strides
    for (int fs = 0; fs < 2; fs++)
      for (int B = 1; B <= 3; B++)
        for (int C = 1; C <= 3; C++) begin
          runSet(bit'(fs), 1'b0, 1'b0, 3'((B + C) % 8), B * 3 + C, B, C, (B % 2) + 1,
                 16'(4 * B - 5), 16'(7 - 3 * C), 16'(C * 64 - 100), 16'(-32 * B),
                 32'h1000_0000 + 32'(B * 16), 32'h2000_0000 - 32'(C * 8));
        end

    // R6 held source, then held destination
    runSet(1'b1, 1'b1, 1'b0, 3'd5, 4, 3, 2, 1, 16'd4, 16'd8, 16'd100, 16'hFF00,
           32'h4000_0000, 32'h5000_0000);
    runSet(1'b0, 1'b0, 1'b1, 3'd2, 2, 2, 3, 3, 16'hFFFC, 16'd12, 16'd20, 16'd40,
           32'h0000_0010, 32'h6000_0000);

    // R9 event after block completion
    syncEv = 1'b1;
    tick();
    syncEv = 1'b0;
    chk(cmdValid == 1'b0, "R9 event after done", 64'(cmdValid), 64'd0);
    tick();
    chk(done == 1'b0, "R9 no done after ignored event", 64'(done), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule